// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit fully differential successive approximation converter. The converter's DAC is split in two. The upper code bits drive a capacitive main array. The lower bits pick a tap on a resistor ladder, and that tap fills in the step between two adjacent codes of the main array. The sequencer holds the trial code, drives the analog switches, and generates the two clock phases of the dynamic comparator. It takes back one decision bit per step.

A start pulse seen while the block is idle begins a fixed sequence. The first phase empties both capacitor arrays. The second phase tracks the input, with the sample and input switches closed while the comparator cancels its offset. The third phase is a binary search that starts at the MSB. Each bit step is four cycles long: a settle cycle, an active comparator cycle, a dead cycle and a standby cycle. The block samples the comparator only on the clock edge that closes the active cycle. On that edge it keeps or clears the bit under test and raises the next lower bit. After the LSB decision it registers the code and raises a done strobe for one cycle.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is held, every switch and comparator clock output, `done`, `result`, `cap_word` and `res_tap` is 0.
- R2: A start seen while idle asserts `sw_dis`, and only `sw_dis`, for exactly DIS_CYC cycles.
- R3: Tracking follows discharge directly. `sw_smp` and `sw_in` are both high for exactly TRK_CYC cycles, and both comparator clocks stay low during this phase.
- R4: The trial code is presented with its bits 11..3 on `cap_word` and its bits 2..0 on `res_tap`.
- R5: The search tests bits from bit 11 down to bit 0. In the k-th active cycle the trial code holds the bits already decided, a 1 in the bit under test and 0 below it. A comparator value of 1 keeps the bit, and 0 clears it.
- R6: In each bit step `phi_act` and `phi_stby` are each high for one cycle. They never overlap, and at least one cycle with both low separates them. A conversion has exactly NBITS active cycles.
- R7: `comp` is sampled only on the edge that ends an active cycle. Its value at any other edge has no effect on the result.
- R8: `done` is high for exactly one cycle. It rises on the (DIS_CYC+TRK_CYC+4*NBITS-2)-th clock edge after the edge that captured start, and `result` then holds the converted code.
- R9: A start asserted during a conversion is ignored. It neither restarts the sequence nor causes an extra discharge.
- R10: `result` keeps its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request |
| comp | input | 1 | Comparator decision, 1 when the input is at or above the trial |
| sw_dis | output | 1 | Array discharge switch |
| sw_smp | output | 1 | Sample switch, closed while tracking |
| sw_in | output | 1 | Input switches, closed while tracking |
| phi_act | output | 1 | Comparator active phase |
| phi_stby | output | 1 | Comparator standby phase |
| cap_word | output | CAP_BITS | Capacitor array control, upper trial bits |
| res_tap | output | NBITS-CAP_BITS | Resistor ladder tap select, lower trial bits |
| result | output | NBITS | Converted code |
| done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The bench builds the block with the default 12-bit code split 9/3 and shortens the phases to DIS_CYC=3 and TRK_CYC=5. With these values each conversion lasts 55 cycles, so full-scale, zero, mid-scale and alternating-bit inputs all fit in one short run. The exact phase lengths and the done latency stay visible in every conversion. The bench's comparator model latches during the active phase and can toggle its output on every other cycle. This shows that decisions depend only on the sampling edge.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int NBITS    = 12,
  parameter int CAP_BITS = 9,
  parameter int DIS_CYC  = 8,
  parameter int TRK_CYC  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      comp,
  output logic                      sw_dis,
  output logic                      sw_smp,
  output logic                      sw_in,
  output logic                      phi_act,
  output logic                      phi_stby,
  output logic [CAP_BITS-1:0]       cap_word,
  output logic [NBITS-CAP_BITS-1:0] res_tap,
  output logic [NBITS-1:0]          result,
  output logic                      done
);
  localparam int RES_BITS = NBITS - CAP_BITS;
  localparam int CMAX     = (DIS_CYC > TRK_CYC) ? DIS_CYC : TRK_CYC;
  localparam int CW       = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam int IW       = $clog2(NBITS);

  typedef enum logic [1:0] {S_IDLE, S_DIS, S_TRK, S_SAR} state_t;

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    bidx;
  logic [1:0]       sub;
  logic [NBITS-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sub    <= '0;
      code   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_DIS;
          cnt  <= '0;
          code <= '0;
        end
        S_DIS: if (cnt == CW'(DIS_CYC - 1)) begin
          st  <= S_TRK;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_TRK: if (cnt == CW'(TRK_CYC - 1)) begin
          st   <= S_SAR;
          code <= {1'b1, {(NBITS-1){1'b0}}};
          bidx <= IW'(NBITS - 1);
          sub  <= '0;
        end else cnt <= cnt + 1'b1;
        S_SAR: begin
          sub <= sub + 1'b1;
          if (sub == 2'd1) begin
            code[bidx] <= comp;
            if (bidx == '0) begin
              result <= {code[NBITS-1:1], comp};
              done   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              code[bidx - 1'b1] <= 1'b1;
              bidx <= bidx - 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sw_dis   = (st == S_DIS);
  assign sw_smp   = (st == S_TRK);
  assign sw_in    = (st == S_TRK);
  assign phi_act  = (st == S_SAR) && (sub == 2'd1);
  assign phi_stby = (st == S_SAR) && (sub == 2'd3);
  assign cap_word = code[NBITS-1:RES_BITS];
  assign res_tap  = code[RES_BITS-1:0];
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_dis,
  input logic             sw_smp,
  input logic             sw_in,
  input logic             phi_act,
  input logic             phi_stby,
  input logic [NBITS-1:0] result,
  input logic             done
);
  assert_dis_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_dis |-> !sw_smp && !sw_in && !phi_act && !phi_stby);

  assert_trk_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_dis) |-> sw_smp && sw_in);

  assert_trk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_smp |-> !phi_act && !phi_stby);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi_act && phi_stby));

  assert_dead_after_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phi_act |=> !phi_stby && !phi_act);

  assert_dead_after_stby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phi_stby |=> !phi_act && !phi_stby);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_smp || phi_act) |=> !sw_dis);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind sar_sequencer sar_sequencer_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;
  localparam int CB = 9;
  localparam int RB = NB - CB;
  localparam int DC = 3;
  localparam int TC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic comp = 1'b0;
  logic sw_dis, sw_smp, sw_in, phi_act, phi_stby, done;
  logic [CB-1:0] cap_word;
  logic [RB-1:0] res_tap;
  logic [NB-1:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int vin = 0;
  logic noise = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_sequencer #(.NBITS(NB), .CAP_BITS(CB), .DIS_CYC(DC), .TRK_CYC(TC)) i_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .comp(comp),
    .sw_dis(sw_dis), .sw_smp(sw_smp), .sw_in(sw_in),
    .phi_act(phi_act), .phi_stby(phi_stby),
    .cap_word(cap_word), .res_tap(res_tap), .result(result), .done(done));

  always @(negedge clk) begin
    if (phi_act) comp <= (vin >= int'({cap_word, res_tap}));
    else if (noise) comp <= ~comp;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input logic noisy, input logic inj_start);
    int n_dis = 0, n_trk = 0, k = 0, bad_cap = 0, bad_tap = 0, lat = 0, other = 0;
    int res_v;
    @(negedge clk);
    vin = v; noise = noisy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      if (sw_dis) begin
        n_dis++;
        if (sw_smp || sw_in || phi_act || phi_stby) other++;
      end
      if (sw_smp && sw_in) begin
        n_trk++;
        if (phi_act || phi_stby) other++;
      end
      if (phi_act) begin
        int b = NB - 1 - k;
        int up = ~((1 << (b + 1)) - 1) & ((1 << NB) - 1);
        int ex = (v & up) | (1 << b);
        if (int'(cap_word) != (ex >> RB)) bad_cap++;
        if (int'(res_tap) != (ex & ((1 << RB) - 1))) bad_tap++;
        k++;
      end
      if (done) begin lat = n; break; end
      start = (inj_start && (n == 4 || n == 12 || n == 30));
      @(negedge clk);
      start = 1'b0;
    end
    res_v = int'(result);
    chk("R2 discharge cycles", n_dis, DC);
    chk("R3 tracking cycles", n_trk, TC);
    chk("R2/R3 exclusive switches and quiet clocks", other, 0);
    chk("R4 cap_word trial upper bits", bad_cap, 0);
    chk("R4 res_tap trial lower bits", bad_tap, 0);
    chk("R6 active phases per conversion", k, NB);
    chk("R8 done latency", lat, DC + TC + 4 * NB - 1);
    chk(noisy ? "R7 result with noisy comparator" : "R5 result", res_v, v);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    for (int i = 0; i < 6; i++) begin
      chk("R9 no restart after ignored start", int'(sw_dis), 0);
      @(negedge clk);
    end
    chk("R10 result held", int'(result), v);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 switches in reset", int'({sw_dis, sw_smp, sw_in}), 0);
    chk("R1 clocks in reset", int'({phi_act, phi_stby, done}), 0);
    chk("R1 result in reset", int'(result), 0);
    chk("R1 trial in reset", int'({cap_word, res_tap}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_extremes;
    run_conv(0, 1'b0, 1'b0);
    run_conv(4095, 1'b0, 1'b0);
    run_conv(2048, 1'b0, 1'b0);
    run_conv(2047, 1'b0, 1'b0);
  endtask

  task automatic test_patterns;
    run_conv(12'hAAA, 1'b0, 1'b0);
    run_conv(12'h555, 1'b0, 1'b0);
    run_conv(1234, 1'b0, 1'b0);
    run_conv(7, 1'b0, 1'b0);
  endtask

  task automatic test_noise;
    run_conv(3000, 1'b1, 1'b0);
    run_conv(8, 1'b1, 1'b0);
    noise = 1'b0;
  endtask

  task automatic test_busy_start;
    run_conv(2900, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_extremes();
    test_patterns();
    test_noise();
    test_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule